// File: doc/BRIEF.md
# Wide register write collector

This block sits between a 32-bit host write port and a set of registers and memory words that are wider than the host bus. The host builds a 128-bit control register out of four dword writes, or a 64-bit memory word out of two. A collector holds the dwords and sends the whole value in one commit only when every part has arrived. Consumers therefore never see a half-updated register.

Two extra classes of address are handled. Plain 32-bit registers go straight through as single-dword commits. Descriptor doorbell registers are write-only and repeat in every address page. A write to the top dword of a doorbell always commits it, and any lower dword the collector does not hold for it goes out as zero. A lower-dword doorbell write that would clash with a different register already being collected is dropped, and the collector is left as it was. Host reads of wide registers and memory words return one 32-bit slice of the last committed value.

Top module: `wide_write_collector`

## Requirements
- R1: A wide register is committed once per set of four dwords, and the dwords may arrive in any order. Dword k of the register (byte offset 4k from its 16-byte-aligned base) lands in commit data bits [32k+31:32k].
- R2: A memory word is committed as soon as both of its dwords are present. Commit data [63:0] holds {upper, lower} and bits [127:64] are zero.
- R3: Addresses are page-mapped. Bits [12:0] are the in-page offset and the bits above them are the page number. Doorbells and plain registers are recognised in every page, and their commit address keeps the page bits.
- R4: A commit is a one-cycle pulse on `cmt_valid`, in the cycle after the write that completes it. It carries the aligned base address and a size code (0 = 32-bit, 1 = 64-bit, 2 = 128-bit). A wide or memory commit empties the collector.
- R5: A write to in-page offset 0x83C or 0xA1C (top dword of the doorbells at 0x830 and 0xA10) always commits 128 bits. Lower dwords come from the collector if it holds them for that same doorbell, and are zero otherwise.
- R6: A write to a lower dword of a doorbell is discarded, leaving the collector unchanged, when the collector holds partial data for another register.
- R7: Writes to in-page offsets 0x400 and 0x420 commit at once with size code 0 and the dword in data [31:0]. They do not touch collected data.
- R8: When the timer-flush option is on, a write to offset 0x420 in page 0 empties the collector. The same write in any other page does not.
- R9: A partial write to a different wide register or memory word drops the held partial data without committing it, and starts collecting the new target.
- R10: A read returns the addressed 32-bit slice of the last committed wide register or memory word. Data still in the collector is never visible, and doorbells and undecoded addresses read zero.
- R11: Reset clears the collector, the commit strobe and all stored register and memory contents.
- R12: A write to an address outside every decoded region produces no commit and leaves the collector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host dword write strobe |
| wr_addr | input | ADDR_W | Byte address of the write, dword aligned |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read, dword aligned |
| rd_data | output | 32 | Read data (combinational) |
| cmt_valid | output | 1 | Commit strobe, one cycle |
| cmt_addr | output | ADDR_W | Aligned base address of the committed item |
| cmt_data | output | 128 | Committed value |
| cmt_size | output | 2 | Commit width code: 0 = 32, 1 = 64, 2 = 128 |

## Verification
The assertions assume that every host address is dword aligned, so bits [1:0] are zero. They also assume at most one write per cycle and that the address and data are steady while `wr_valid` is high. The properties on doorbell drops, dword growth and flushing are only meaningful under those assumptions. The stimulus uses only aligned addresses and issues each write as a single-cycle strobe followed by an idle cycle. Every commit is therefore sampled alone, and no two collector updates fall in the same cycle.

// File: rtl/wwc_pkg.sv
// Package: shared types and fixed in-page offsets for the wide write collector.
// Assumes a page of 2**PAGE_SHIFT bytes and dword-aligned host addresses.
package wwc_pkg;
    localparam int PAGE_SHIFT = 13;
    localparam int IDX_W      = 8;

    localparam logic [PAGE_SHIFT-1:0] OFS_DOOR_A = 13'h830;
    localparam logic [PAGE_SHIFT-1:0] OFS_DOOR_B = 13'hA10;
    localparam logic [PAGE_SHIFT-1:0] OFS_EVQ    = 13'h400;
    localparam logic [PAGE_SHIFT-1:0] OFS_TIMER  = 13'h420;

    localparam logic [1:0] SZ32  = 2'd0;
    localparam logic [1:0] SZ64  = 2'd1;
    localparam logic [1:0] SZ128 = 2'd2;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_PLAIN = 3'd1,
        K_WIDE  = 3'd2,
        K_SRAM  = 3'd3,
        K_DOOR  = 3'd4
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [1:0]       dw;
        logic [IDX_W-1:0] idx;
        logic             timer_pg0;
    } dec_t;
endpackage

// File: rtl/wwc_addr_decode.sv
// Address decoder: classifies a byte address as plain, wide, memory word,
// doorbell or undecoded. It also gives the aligned base, the dword number and
// the item index. Assumes the wide and memory windows lie in page 0, do not
// overlap the fixed offsets, and each hold at most 2**IDX_W items.
module wwc_addr_decode
    import wwc_pkg::*;
#(
    parameter int                    ADDR_W    = 16,
    parameter int                    NUM_WIDE  = 4,
    parameter int                    NUM_SRAM  = 8,
    parameter logic [PAGE_SHIFT-1:0] WIDE_BASE = 13'h000,
    parameter logic [PAGE_SHIFT-1:0] SRAM_BASE = 13'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [ADDR_W-1:0] base
);
    localparam logic [PAGE_SHIFT:0] WIDE_SPAN = (PAGE_SHIFT+1)'(NUM_WIDE * 16);
    localparam logic [PAGE_SHIFT:0] SRAM_SPAN = (PAGE_SHIFT+1)'(NUM_SRAM * 8);

    logic [PAGE_SHIFT-1:0] ofs;
    logic                  pg0;
    logic [PAGE_SHIFT:0]   rel_w, rel_s;
    logic                  in_w, in_s, is_door;

    // Split the address into page and offset, and locate the wide and memory windows.
    always_comb begin
        ofs     = addr[PAGE_SHIFT-1:0];
        pg0     = (addr[ADDR_W-1:PAGE_SHIFT] == '0);
        rel_w   = {1'b0, ofs} - {1'b0, WIDE_BASE};
        rel_s   = {1'b0, ofs} - {1'b0, SRAM_BASE};
        in_w    = pg0 && !rel_w[PAGE_SHIFT] && (rel_w < WIDE_SPAN);
        in_s    = pg0 && !rel_s[PAGE_SHIFT] && (rel_s < SRAM_SPAN);
        is_door = ({ofs[PAGE_SHIFT-1:4], 4'b0} == OFS_DOOR_A) ||
                  ({ofs[PAGE_SHIFT-1:4], 4'b0} == OFS_DOOR_B);
    end

    // Pick the class; plain and doorbell offsets take precedence over the windows.
    always_comb begin
        dec       = '{kind: K_NONE, dw: ofs[3:2], idx: '0, timer_pg0: 1'b0};
        base      = addr;
        if (ofs == OFS_EVQ || ofs == OFS_TIMER) begin
            dec.kind      = K_PLAIN;
            dec.timer_pg0 = pg0 && (ofs == OFS_TIMER);
        end else if (is_door) begin
            dec.kind = K_DOOR;
            base     = {addr[ADDR_W-1:4], 4'b0};
        end else if (in_w) begin
            dec.kind = K_WIDE;
            dec.idx  = IDX_W'(rel_w >> 4);
            base     = {addr[ADDR_W-1:4], 4'b0};
        end else if (in_s) begin
            dec.kind = K_SRAM;
            dec.dw   = {1'b0, ofs[2]};
            dec.idx  = IDX_W'(rel_s >> 3);
            base     = {addr[ADDR_W-1:3], 3'b0};
        end
    end
endmodule

// File: rtl/wwc_collector.sv
// Collector: holds one tag, a dword valid mask and four data dwords. It
// applies the commit rules for wide, memory, doorbell and plain writes and
// registers the commit port. Assumes one write per cycle, already decoded.
module wwc_collector
    import wwc_pkg::*;
#(
    parameter int   ADDR_W      = 16,
    parameter logic TIMER_FLUSH = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [31:0]        wr_data,
    input  dec_t               wdec,
    input  logic [ADDR_W-1:0]  wbase,
    output logic               cmt_valid,
    output logic [ADDR_W-1:0]  cmt_addr,
    output logic [127:0]       cmt_data,
    output logic [1:0]         cmt_size
);
    logic [ADDR_W-1:0]  col_tag, nx_tag;
    logic [3:0]         col_mask, nx_mask, merged, full;
    logic [3:0][31:0]   col_data, nx_data, asm;
    logic               hit, c_v;
    logic [1:0]         c_sz;
    logic [ADDR_W-1:0]  c_a;
    logic [127:0]       c_d;

    // Next-state and commit decision for the current host write.
    always_comb begin
        nx_tag  = col_tag;
        nx_mask = col_mask;
        nx_data = col_data;
        c_v     = 1'b0;
        c_sz    = SZ32;
        c_a     = wbase;
        c_d     = '0;
        hit     = (col_mask != 4'b0) && (col_tag == wbase);
        merged  = hit ? col_mask : 4'b0;
        merged[wdec.dw] = 1'b1;
        asm     = col_data;
        asm[wdec.dw] = wr_data;
        full    = (wdec.kind == K_WIDE) ? 4'hF : 4'h3;
        if (wr_valid) begin
            case (wdec.kind)
                K_PLAIN: begin
                    c_v = 1'b1;
                    c_d = {96'b0, wr_data};
                    if (TIMER_FLUSH && wdec.timer_pg0) begin
                        nx_mask = '0;
                        nx_tag  = '0;
                    end
                end
                K_DOOR: begin
                    if (wdec.dw == 2'd3) begin
                        c_v  = 1'b1;
                        c_sz = SZ128;
                        for (int i = 0; i < 3; i++)
                            c_d[32*i +: 32] = (hit && col_mask[i]) ? col_data[i] : 32'b0;
                        c_d[127:96] = wr_data;
                        if (hit) begin
                            nx_mask = '0;
                            nx_tag  = '0;
                        end
                    end else if (col_mask == 4'b0 || hit) begin
                        nx_mask = merged;
                        nx_tag  = wbase;
                        nx_data = asm;
                    end
                end
                K_WIDE, K_SRAM: begin
                    if (merged == full) begin
                        c_v     = 1'b1;
                        c_sz    = (wdec.kind == K_WIDE) ? SZ128 : SZ64;
                        c_d     = (wdec.kind == K_WIDE) ? 128'(asm) : {64'b0, asm[1], asm[0]};
                        nx_mask = '0;
                        nx_tag  = '0;
                    end else begin
                        nx_mask = merged;
                        nx_tag  = wbase;
                        nx_data = asm;
                    end
                end
                default: ;
            endcase
        end
    end

    // Collector state and registered commit port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_tag   <= '0;
            col_mask  <= '0;
            col_data  <= '0;
            cmt_valid <= 1'b0;
            cmt_addr  <= '0;
            cmt_data  <= '0;
            cmt_size  <= SZ32;
        end else begin
            col_tag   <= nx_tag;
            col_mask  <= nx_mask;
            col_data  <= nx_data;
            cmt_valid <= c_v;
            cmt_addr  <= c_a;
            cmt_data  <= c_d;
            cmt_size  <= c_sz;
        end
    end

    AST_MASK_GROWS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_mask) <= $countones($past(col_mask)) + 1); // R1
    AST_MEM_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_size == SZ64) |-> (col_mask == 4'b0)); // R2
    AST_COMMIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> $past(wr_valid)); // R4
    AST_DOOR_TOP_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wdec.kind == K_DOOR && wdec.dw == 2'd3) |=> (cmt_valid && cmt_size == SZ128)); // R5
    AST_DOOR_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wdec.kind == K_DOOR && wdec.dw == 2'd3 && col_mask == 4'b0)
        |=> (cmt_data[95:0] == 96'b0)); // R5
    AST_DOOR_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wdec.kind == K_DOOR && wdec.dw != 2'd3 && col_mask != 4'b0 && col_tag != wbase)
        |=> ($stable(col_mask) && $stable(col_tag))); // R6
    AST_PLAIN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wdec.kind == K_PLAIN) |=> (cmt_valid && cmt_size == SZ32 && cmt_data[31:0] == $past(wr_data))); // R7
    AST_TIMER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (TIMER_FLUSH && wr_valid && wdec.kind == K_PLAIN && wdec.timer_pg0) |=> (col_mask == 4'b0)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (col_mask == 4'b0 && !cmt_valid)); // R11
endmodule

// File: rtl/wwc_shadow.sv
// Shadow store: keeps the last committed value of each wide register and
// memory word, updated from the commit port, and serves host dword reads.
// Assumes NUM_WIDE and NUM_SRAM are powers of two, at least 2.
module wwc_shadow
    import wwc_pkg::*;
#(
    parameter int                    ADDR_W    = 16,
    parameter int                    NUM_WIDE  = 4,
    parameter int                    NUM_SRAM  = 8,
    parameter logic [PAGE_SHIFT-1:0] WIDE_BASE = 13'h000,
    parameter logic [PAGE_SHIFT-1:0] SRAM_BASE = 13'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmt_valid,
    input  logic [ADDR_W-1:0]  cmt_addr,
    input  logic [127:0]       cmt_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data
);
    localparam int WI_W = $clog2(NUM_WIDE);
    localparam int SI_W = $clog2(NUM_SRAM);

    dec_t              cdec, rdec;
    logic [ADDR_W-1:0] unused_cbase, unused_rbase;
    logic [NUM_WIDE-1:0][3:0][31:0] wide_q;
    logic [NUM_SRAM-1:0][1:0][31:0] sram_q;

    wwc_addr_decode #(.ADDR_W(ADDR_W), .NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM),
                      .WIDE_BASE(WIDE_BASE), .SRAM_BASE(SRAM_BASE))
        u_cdec (.addr(cmt_addr), .dec(cdec), .base(unused_cbase));
    wwc_addr_decode #(.ADDR_W(ADDR_W), .NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM),
                      .WIDE_BASE(WIDE_BASE), .SRAM_BASE(SRAM_BASE))
        u_rdec (.addr(rd_addr), .dec(rdec), .base(unused_rbase));

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        // Capture a 128-bit commit aimed at wide register g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wide_q[g] <= '0;
            else if (cmt_valid && cdec.kind == K_WIDE && cdec.idx == IDX_W'(g))
                wide_q[g] <= cmt_data;
        end
    end

    for (genvar g = 0; g < NUM_SRAM; g++) begin : g_sram
        // Capture a 64-bit commit aimed at memory word g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sram_q[g] <= '0;
            else if (cmt_valid && cdec.kind == K_SRAM && cdec.idx == IDX_W'(g))
                sram_q[g] <= cmt_data[63:0];
        end
    end

    // Return the addressed dword of committed contents; everything else reads zero.
    always_comb begin
        case (rdec.kind)
            K_WIDE:  rd_data = wide_q[rdec.idx[WI_W-1:0]][rdec.dw];
            K_SRAM:  rd_data = sram_q[rdec.idx[SI_W-1:0]][rdec.dw[0]];
            default: rd_data = 32'b0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{cmt_data[127:64], cdec.dw, cdec.timer_pg0, rdec.timer_pg0,
                           rdec.idx, cdec.idx};

    AST_DOOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdec.kind == K_DOOR) |-> (rd_data == 32'b0)); // R10
endmodule

// File: rtl/wide_write_collector.sv
// Top: host dword writes in, atomic wide commits out, committed-value reads.
// Assumes dword-aligned addresses and at most one host write per cycle.
module wide_write_collector
    import wwc_pkg::*;
#(
    parameter int                    ADDR_W      = 16,
    parameter int                    NUM_WIDE    = 4,
    parameter int                    NUM_SRAM    = 8,
    parameter logic [PAGE_SHIFT-1:0] WIDE_BASE   = 13'h000,
    parameter logic [PAGE_SHIFT-1:0] SRAM_BASE   = 13'h100,
    parameter logic                  TIMER_FLUSH = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic               cmt_valid,
    output logic [ADDR_W-1:0]  cmt_addr,
    output logic [127:0]       cmt_data,
    output logic [1:0]         cmt_size
);
    dec_t              wdec;
    logic [ADDR_W-1:0] wbase;

    wwc_addr_decode #(.ADDR_W(ADDR_W), .NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM),
                      .WIDE_BASE(WIDE_BASE), .SRAM_BASE(SRAM_BASE))
        u_wdec (.addr(wr_addr), .dec(wdec), .base(wbase));

    wwc_collector #(.ADDR_W(ADDR_W), .TIMER_FLUSH(TIMER_FLUSH))
        u_col (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
               .wdec(wdec), .wbase(wbase), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr),
               .cmt_data(cmt_data), .cmt_size(cmt_size));

    wwc_shadow #(.ADDR_W(ADDR_W), .NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM),
                 .WIDE_BASE(WIDE_BASE), .SRAM_BASE(SRAM_BASE))
        u_shd (.clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr),
               .cmt_data(cmt_data), .rd_addr(rd_addr), .rd_data(rd_data));

    logic unused_idx;
    assign unused_idx = ^wdec.idx;
endmodule

// File: tb/test_wide_write_collector.sv
module test_wide_write_collector;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [15:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [15:0]  rd_addr = '0;
    logic [31:0]  rd_data;
    logic         cmt_valid;
    logic [15:0]  cmt_addr;
    logic [127:0] cmt_data;
    logic [1:0]   cmt_size;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wide_write_collector i_wide_write_collector (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr),
        .cmt_data(cmt_data), .cmt_size(cmt_size));

    typedef struct packed {
        logic [15:0]  a;
        logic [31:0]  d;
        logic         ev;
        logic [1:0]   sz;
        logic [15:0]  ea;
        logic [127:0] ed;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        '{16'h0010, 32'hA0000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd1},   // R1
        '{16'h0018, 32'hA0000002, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd1},   // R1
        '{16'h001C, 32'hA0000003, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd1},   // R1
        '{16'h0014, 32'hA0000001, 1'b1, 2'd2, 16'h0010,
          {32'hA0000003, 32'hA0000002, 32'hA0000001, 32'hA0000000}, 4'd1}, // R1 R4
        '{16'h0108, 32'hB0000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd2},   // R2
        '{16'h010C, 32'hB0000001, 1'b1, 2'd1, 16'h0108,
          {64'h0, 32'hB0000001, 32'hB0000000}, 4'd2},                     // R2
        '{16'h2400, 32'hC0000000, 1'b1, 2'd0, 16'h2400, {96'h0, 32'hC0000000}, 4'd3}, // R3 R7
        '{16'h2830, 32'hD0000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd5},   // R5
        '{16'h2834, 32'hD0000001, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd5},   // R5
        '{16'h283C, 32'hD0000003, 1'b1, 2'd2, 16'h2830,
          {32'hD0000003, 32'h0, 32'hD0000001, 32'hD0000000}, 4'd5},       // R5 zero fill
        '{16'h4A1C, 32'hE0000003, 1'b1, 2'd2, 16'h4A10, {32'hE0000003, 96'h0}, 4'd3}, // R3 R5
        '{16'h0020, 32'hF0000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd6},   // R6
        '{16'h0A14, 32'h60000001, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd6},   // R6 dropped
        '{16'h0024, 32'hF0000001, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd6},   // R6
        '{16'h0028, 32'hF0000002, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd6},   // R6
        '{16'h002C, 32'hF0000003, 1'b1, 2'd2, 16'h0020,
          {32'hF0000003, 32'hF0000002, 32'hF0000001, 32'hF0000000}, 4'd6}, // R6
        '{16'h0030, 32'h70000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd12},  // R12
        '{16'h0040, 32'hBAD00000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd12},  // R12 undecoded
        '{16'h0034, 32'h70000001, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd12},  // R12
        '{16'h0038, 32'h70000002, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd12},  // R12
        '{16'h003C, 32'h70000003, 1'b1, 2'd2, 16'h0030,
          {32'h70000003, 32'h70000002, 32'h70000001, 32'h70000000}, 4'd12}, // R12
        '{16'h0000, 32'h80000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd9},   // R9
        '{16'h0010, 32'h90000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd9},   // R9 flush
        '{16'h0014, 32'h90000001, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd9},   // R9
        '{16'h0018, 32'h90000002, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd9},   // R9
        '{16'h001C, 32'h90000003, 1'b1, 2'd2, 16'h0010,
          {32'h90000003, 32'h90000002, 32'h90000001, 32'h90000000}, 4'd9}, // R9
        '{16'h0004, 32'h80000001, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd9},   // R9
        '{16'h0008, 32'h80000002, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd9},   // R9
        '{16'h000C, 32'h80000003, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd9},   // R9 old dword gone
        '{16'h0000, 32'h81000000, 1'b1, 2'd2, 16'h0000,
          {32'h80000003, 32'h80000002, 32'h80000001, 32'h81000000}, 4'd9}, // R9
        '{16'h0A10, 32'hC1000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd5},   // R5
        '{16'h2420, 32'hC2000000, 1'b1, 2'd0, 16'h2420, {96'h0, 32'hC2000000}, 4'd8}, // R8 page 1
        '{16'h0A18, 32'hC1000002, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd5},   // R5
        '{16'h0A1C, 32'hC1000003, 1'b1, 2'd2, 16'h0A10,
          {32'hC1000003, 32'hC1000002, 32'h0, 32'hC1000000}, 4'd5},       // R5 held dwords
        '{16'h0000, 32'hD1000000, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd8},   // R8
        '{16'h0420, 32'hD2000000, 1'b1, 2'd0, 16'h0420, {96'h0, 32'hD2000000}, 4'd7}, // R7 R8
        '{16'h0004, 32'hD1000001, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd8},   // R8
        '{16'h0008, 32'hD1000002, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd8},   // R8
        '{16'h000C, 32'hD1000003, 1'b0, 2'd0, 16'h0000, 128'h0, 4'd8},   // R8 flushed
        '{16'h0000, 32'hD1000004, 1'b1, 2'd2, 16'h0000,
          {32'hD1000003, 32'hD1000002, 32'hD1000001, 32'hD1000004}, 4'd8}  // R8
    };

    task automatic chk(input int req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        rd_addr = a;
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(11, "cmt_valid in reset", {127'b0, cmt_valid}, 128'h0);
        rd(16'h0010);
        chk(11, "read in reset", {96'b0, rd_data}, 128'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].d);
            chk(int'(VEC[i].req), "commit strobe", {127'b0, cmt_valid}, {127'b0, VEC[i].ev});
            if (VEC[i].ev) begin
                chk(int'(VEC[i].req), "commit size", {126'b0, cmt_size}, {126'b0, VEC[i].sz});
                chk(int'(VEC[i].req), "commit addr", {112'b0, cmt_addr}, {112'b0, VEC[i].ea});
                chk(int'(VEC[i].req), "commit data", cmt_data, VEC[i].ed);
            end
        end

        // R4: strobe lasts one cycle
        @(negedge clk);
        chk(4, "strobe dropped", {127'b0, cmt_valid}, 128'h0);

        // R10: reads of committed contents
        rd(16'h0018);
        chk(10, "read wide dword 2", {96'b0, rd_data}, {96'b0, 32'h90000002});
        rd(16'h0004);
        chk(10, "read wide reg 0 dword 1", {96'b0, rd_data}, {96'b0, 32'hD1000001});
        rd(16'h010C);
        chk(10, "read memory upper", {96'b0, rd_data}, {96'b0, 32'hB0000001});
        rd(16'h2830);
        chk(10, "doorbell reads zero", {96'b0, rd_data}, 128'h0);
        wr(16'h0030, 32'h55550000);
        rd(16'h0030);
        chk(10, "uncommitted hidden", {96'b0, rd_data}, {96'b0, 32'h70000000});

        // R11: reset mid-collection
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(11, "strobe after reset", {127'b0, cmt_valid}, 128'h0);
        rd(16'h0018);
        chk(11, "store cleared", {96'b0, rd_data}, 128'h0);
        @(negedge clk);
        rst_n = 1'b1;
        wr(16'h0034, 32'h56000001);
        wr(16'h0038, 32'h56000002);
        wr(16'h003C, 32'h56000003);
        chk(11, "held dword cleared", {127'b0, cmt_valid}, 128'h0);
        wr(16'h0030, 32'h56000000);
        chk(11, "fresh commit", cmt_data, {32'h56000003, 32'h56000002, 32'h56000001, 32'h56000000});

        done = 1'b1;
        finish_run();
    end
endmodule